// File: doc/BRIEF.md
# Configurable Pad Input/Output Cell

This block is a synthesizable model of one programmable I/O cell at the edge of a logic array. A pad is represented by three plain signals: `pad_in` carries the value arriving from outside, and `pad_out` and `pad_oe` carry the value and the drive enable going out. No true tristate net is used. A static configuration word sets up the cell. It is loaded while reset is held and is then left alone.

The input side has one storage element with its own clock, `clk_in`. That element works either as an edge flip-flop or as a level-sensitive latch. Two internal taps each return either the raw pad value or the stored value. The output side has its own clock, `clk_out`, and can invert the core's output value. The inverted value can pass to the pad directly or go through an edge flip-flop. The output enable also has a selectable polarity. Each clock has its own inversion bit. Each storage element has its own preset-or-clear value, which a global active-low reset applies asynchronously.

Top module: `pio_cell`

## Requirements
- R1: Configuration bit 0 selects what `tap1` returns and bit 1 selects what `tap2` returns. A value of 0 returns `pad_in` combinationally and 1 returns the input storage element.
- R2: When bit 2 is 0, the input element is a flip-flop. It captures `pad_in` on the rising edge of the effective input clock, which is `clk_in` XOR bit 3, so bit 3 set means capture on the falling edge.
- R3: When bit 2 is 1, the input element is a latch. It follows `pad_in` while the effective input clock is 1 and holds while that clock is 0.
- R4: The output value is `core_out` XOR bit 5. When bit 6 is 0, this value reaches `pad_out` combinationally.
- R5: When bit 6 is 1, `pad_out` shows an output flip-flop. That flip-flop captures `core_out` XOR bit 5 on the rising edge of `clk_out` XOR bit 7.
- R6: `pad_oe` equals `core_oe` XOR bit 8. Whenever `pad_oe` is 0, `pad_out` is 0.
- R7: While `rst_n` is 0, the input element holds bit 4 and the output element holds bit 9, regardless of clock edges or latch enable. Reset takes effect without a clock.
- R8: Edges on `clk_out` do not change the input element, and edges on `clk_in` do not change the output element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock for the input storage element |
| clk_out | input | 1 | Clock for the output storage element |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| cfg | input | 10 | Static configuration word (bit meanings in R1 to R7) |
| pad_in | input | 1 | Value arriving at the pad |
| core_out | input | 1 | Output value from the core |
| core_oe | input | 1 | Output enable from the core, before polarity |
| tap1 | output | 1 | First input tap to the core |
| tap2 | output | 1 | Second input tap to the core |
| pad_out | output | 1 | Value driven to the pad; 0 when not enabled |
| pad_oe | output | 1 | Pad drive enable |

## Verification
Taps on the direct path, the unregistered output and the enable are due in the same time step as the change that causes them. Stored values are due right after the effective clock edge, or at once when latch mode and a high effective level make the input element transparent. The bench changes only one input per step, updates its reference model of both elements, and samples 2 ns after the change, away from any edge. It then holds all inputs still for another nanosecond while the monitor compares. All 1024 configuration words are swept, and each sweep includes a reset pulse that arrives while both clocks toggle.

// File: rtl/pio_cell_pkg.sv
// Package: configuration word layout shared by the cell and its sub-blocks.
// Assumes the word is static after reset is released.
package pio_cell_pkg;

    localparam int CFG_W = 10;

    typedef struct packed {
        logic out_rst_val;   // bit 9: output element reset value
        logic oe_inv;        // bit 8: enable polarity
        logic out_clk_inv;   // bit 7: output clock polarity
        logic out_reg;       // bit 6: registered output
        logic out_inv;       // bit 5: output polarity
        logic in_rst_val;    // bit 4: input element reset value
        logic in_clk_inv;    // bit 3: input clock polarity
        logic in_latch;      // bit 2: latch instead of flip-flop
        logic tap2_stored;   // bit 1: tap2 source
        logic tap1_stored;   // bit 0: tap1 source
    } pio_cfg_t;

endpackage

// File: rtl/pio_store.sv
// Storage element: an edge flip-flop or a level latch, chosen by latch_mode.
// The clock polarity is selectable. An asynchronous active-low reset loads rst_val.
// Assumes clk_inv and latch_mode change only while rst_n is low.
module pio_store (
    input  logic clk,
    input  logic clk_inv,
    input  logic latch_mode,
    input  logic rst_n,
    input  logic rst_val,
    input  logic d,
    output logic q
);
    logic eff_clk;
    logic q_ff;
    logic q_lat;

    assign eff_clk = clk ^ clk_inv;

    // Edge flip-flop on the effective clock, with asynchronous preset or clear
    always_ff @(posedge eff_clk or negedge rst_n) begin
        if (!rst_n) q_ff <= rst_val;
        else        q_ff <= d;
    end

    // Latch that is transparent while the effective clock is high; reset wins
    always_latch begin
        if (!rst_n)       q_lat = rst_val;
        else if (eff_clk) q_lat = d;
    end

    // Pick the element that the configuration selects
    assign q = latch_mode ? q_lat : q_ff;
endmodule

// File: rtl/pio_in_path.sv
// Input side: stores pad_in and drives the two taps.
// Each tap returns either the direct pad value or the stored value.
module pio_in_path
    import pio_cell_pkg::*;
(
    input  logic     clk_in,
    input  logic     rst_n,
    input  pio_cfg_t cfg,
    input  logic     pad_in,
    output logic     tap1,
    output logic     tap2
);
    logic stored;

    pio_store u_store (
        .clk       (clk_in),
        .clk_inv   (cfg.in_clk_inv),
        .latch_mode(cfg.in_latch),
        .rst_n     (rst_n),
        .rst_val   (cfg.in_rst_val),
        .d         (pad_in),
        .q         (stored)
    );

    // Tap multiplexers
    assign tap1 = cfg.tap1_stored ? stored : pad_in;
    assign tap2 = cfg.tap2_stored ? stored : pad_in;

    // Rising-edge flip-flop: tap1 shows the value captured at the previous edge
    assert_in_rise_capture_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!cfg.in_latch && !cfg.in_clk_inv && cfg.tap1_stored && $past(rst_n) && $stable(cfg))
        |-> (tap1 == $past(pad_in)));

    // Falling-edge flip-flop: tap2 shows the value captured at the previous falling edge
    assert_in_fall_capture_R2: assert property (@(negedge clk_in) disable iff (!rst_n)
        (!cfg.in_latch && cfg.in_clk_inv && cfg.tap2_stored && $past(rst_n) && $stable(cfg))
        |-> (tap2 == $past(pad_in)));

    // Latch was transparent through the high phase that is now closing
    assert_latch_transparent_R3: assert property (@(negedge clk_in) disable iff (!rst_n)
        (cfg.in_latch && !cfg.in_clk_inv && cfg.tap1_stored)
        |-> (tap1 == pad_in));
endmodule

// File: rtl/pio_out_path.sv
// Output side: applies polarity, optionally registers the value, and gates it
// with the enable after that enable's own polarity. pad_out is 0 when not enabled.
module pio_out_path
    import pio_cell_pkg::*;
(
    input  logic     clk_out,
    input  logic     rst_n,
    input  pio_cfg_t cfg,
    input  logic     core_out,
    input  logic     core_oe,
    output logic     pad_out,
    output logic     pad_oe
);
    logic out_pol;
    logic out_q;
    logic out_sel;

    assign out_pol = core_out ^ cfg.out_inv;

    pio_store u_store (
        .clk       (clk_out),
        .clk_inv   (cfg.out_clk_inv),
        .latch_mode(1'b0),
        .rst_n     (rst_n),
        .rst_val   (cfg.out_rst_val),
        .d         (out_pol),
        .q         (out_q)
    );

    // Choose between the direct and the registered output value
    assign out_sel = cfg.out_reg ? out_q : out_pol;

    // Enable polarity and gating of the pad value
    assign pad_oe  = core_oe ^ cfg.oe_inv;
    assign pad_out = pad_oe & out_sel;

    // An undriven pad carries 0
    assert_idle_low_R6: assert property (@(posedge clk_out) disable iff (!rst_n)
        !pad_oe |-> !pad_out);

    // Registered output shows the polarity-adjusted value captured at the previous edge
    assert_out_capture_R5: assert property (@(posedge clk_out) disable iff (!rst_n)
        (cfg.out_reg && !cfg.out_clk_inv && pad_oe && $past(rst_n) && $stable(cfg))
        |-> (pad_out == $past(core_out ^ cfg.out_inv)));
endmodule

// File: rtl/pio_cell.sv
// Top level of the configurable pad cell.
// Splits the configuration word and connects the input and output sides.
// Assumes cfg is written only while rst_n is low.
module pio_cell
    import pio_cell_pkg::*;
(
    input  logic             clk_in,
    input  logic             clk_out,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             pad_in,
    input  logic             core_out,
    input  logic             core_oe,
    output logic             tap1,
    output logic             tap2,
    output logic             pad_out,
    output logic             pad_oe
);
    pio_cfg_t cfg_s;

    // Map the flat word onto its fields
    assign cfg_s = pio_cfg_t'(cfg);

    pio_in_path u_in (
        .clk_in(clk_in),
        .rst_n (rst_n),
        .cfg   (cfg_s),
        .pad_in(pad_in),
        .tap1  (tap1),
        .tap2  (tap2)
    );

    pio_out_path u_out (
        .clk_out (clk_out),
        .rst_n   (rst_n),
        .cfg     (cfg_s),
        .core_out(core_out),
        .core_oe (core_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: tb/tb_pio_cell.sv
module tb_pio_cell;
    typedef struct {
        logic  t1;
        logic  t2;
        logic  po;
        logic  poe;
        string tag;
    } exp_t;

    logic       clk;
    logic       clk_in, clk_out, rst_n;
    logic [9:0] cfg;
    logic       pad_in, core_out, core_oe;
    logic       tap1, tap2, pad_out, pad_oe;

    int   n_chk  = 0;
    int   n_fail = 0;
    int   cycles = 0;
    logic m_in, m_out;   // reference model of the two storage elements
    exp_t q[$];

    pio_cell dut (
        .clk_in(clk_in), .clk_out(clk_out), .rst_n(rst_n), .cfg(cfg),
        .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .tap1(tap1), .tap2(tap2), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    initial clk = 0;
    always #2.5 clk = ~clk;   // 200 MHz pacing clock

    function automatic logic eff_in();
        return clk_in ^ cfg[3];
    endfunction

    function automatic logic eff_out();
        return clk_out ^ cfg[7];
    endfunction

    // Driver side: compute the expected outputs from the model and queue them
    task automatic push(string tag);
        exp_t e;
        e.t1  = cfg[0] ? m_in : pad_in;     // R1
        e.t2  = cfg[1] ? m_in : pad_in;
        e.poe = core_oe ^ cfg[8];           // R6
        e.po  = e.poe ? (cfg[6] ? m_out : (core_out ^ cfg[5])) : 1'b0;
        e.tag = tag;
        q.push_back(e);
        #1;
    endtask

    task automatic latch_follow();
        if (rst_n && cfg[2] && eff_in()) m_in = pad_in;
    endtask

    task automatic set_pad(logic v);
        pad_in = v;
        #2;
        latch_follow();
        push(cfg[2] ? "R3 R1" : "R1");
    endtask

    task automatic step_in(logic v);
        logic old;
        old = eff_in();
        clk_in = v;
        #2;
        if (rst_n && !cfg[2] && !old && eff_in()) m_in = pad_in;
        latch_follow();
        push(cfg[2] ? "R3" : "R2 R8");
    endtask

    task automatic set_core(logic o, logic e);
        core_out = o;
        core_oe  = e;
        #2;
        push("R4 R6");
    endtask

    task automatic step_out(logic v);
        logic old;
        old = eff_out();
        clk_out = v;
        #2;
        if (rst_n && cfg[6] && !old && eff_out()) m_out = core_out ^ cfg[5];
        else if (rst_n && !old && eff_out()) m_out = core_out ^ cfg[5];
        push("R5 R8");
    endtask

    // Monitor side: pop each expected item and compare it with the outputs
    initial begin
        forever begin
            wait (q.size() != 0);
            begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (tap1 !== e.t1 || tap2 !== e.t2 || pad_out !== e.po || pad_oe !== e.poe) begin
                    n_fail++;
                    $display("FAIL %s cfg=%b: got t1=%b t2=%b po=%b oe=%b exp t1=%b t2=%b po=%b oe=%b",
                             e.tag, cfg, tap1, tap2, pad_out, pad_oe, e.t1, e.t2, e.po, e.poe);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clk_in = 0; clk_out = 0; cfg = '0;
        pad_in = 0; core_out = 0; core_oe = 0;
        #3;
        for (int c = 0; c < 1024; c++) begin
            // R7: load the word under reset, check the preset or clear values
            rst_n = 0;
            clk_in = 0; clk_out = 0;
            cfg = c[9:0];
            pad_in = 1'($urandom); core_out = 1'($urandom); core_oe = 1'($urandom);
            #2;
            m_in = cfg[4]; m_out = cfg[9];
            push("R7");
            rst_n = 1;
            #2;
            latch_follow();
            push("R7 R3");
            for (int k = 0; k < 2; k++) begin
                set_pad(1'($urandom));
                step_in(1);
                set_pad(~pad_in);          // R3: transparency while high when inverted clock is off
                set_pad(~pad_in);
                step_in(0);
                set_pad(~pad_in);          // R3: transparency with inverted clock
                set_core(1'($urandom), 1'b1 ^ cfg[8]);
                step_out(1);
                set_core(~core_out, 1'($urandom));
                step_out(0);
                set_core(~core_out, 1'b1 ^ cfg[8]);
            end
            // R7: reset mid-run wins over clock edges and latch enable
            rst_n = 0;
            #2;
            m_in = cfg[4]; m_out = cfg[9];
            push("R7");
            step_in(1);
            step_out(1);
            set_pad(~pad_in);
            step_in(0);
            step_out(0);
            rst_n = 1;
            #2;
            latch_follow();
            push("R7 R3");
        end
        wait (q.size() == 0);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule